// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It protects an instruction that needs a register value which an older memory load has not produced yet. The load sits one stage ahead, in execute. Each cycle the block compares the destination register of that load with the two source register fields of the instruction being decoded. On a match it holds the program counter and the fetch/decode register for one cycle, so the same instruction is decoded again and the next one is fetched again. In that same cycle it writes an all-zero control word into the decode/execute register, which sends a no-operation down the pipe.

The block owns the control and destination-register portion of the decode/execute pipeline register. It therefore also supplies the memory-read flag and the destination field that it compares against in the next cycle. Because the bubble carries a cleared memory-read flag, a stall ends after one cycle. The dependent instruction then reaches execute one cycle behind the load, and the existing forwarding network delivers the loaded value from the memory/writeback register.

Top module: `lu_hazard_unit`

## Requirements
- R1: When the memory-read bit (bit MEMRD_BIT of `ex_ctrl`) is 1, `ex_rt` is nonzero and `ex_rt` equals `id_rs`, both `pc_wr_en` and `ifid_wr_en` are 0 in that cycle.
- R2: When the memory-read bit is 1, `ex_rt` is nonzero and `ex_rt` equals `id_rt`, both `pc_wr_en` and `ifid_wr_en` are 0 in that cycle.
- R3: A load whose destination `ex_rt` is register 0 never causes a stall, whatever the source fields hold.
- R4: When the memory-read bit is 0, no stall occurs, even when the register numbers match.
- R5: `pc_wr_en` and `ifid_wr_en` are active-high and always equal. They are 1 in every cycle in which neither R1 nor R2 applies.
- R6: After a clock edge in a stall cycle, `ex_ctrl` is all zeros. After an edge in a non-stall cycle, `ex_ctrl` equals the `id_ctrl` presented before that edge. `ex_rt` takes `id_rt` at every edge.
- R7: A stall never lasts for two consecutive cycles.
- R8: While `rst` is high, `ex_ctrl` and `ex_rt` are cleared at each clock edge, and both write enables are 1.
- R9: A load followed directly by an instruction that reads the loaded register costs exactly one extra cycle of front-end progress. A load followed by an independent instruction costs none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | REG_W | First source register field of the instruction in decode |
| id_rt | input | REG_W | Second source register field (also the load destination) in decode |
| id_ctrl | input | CTRL_W | Control word produced by the decoder for that instruction |
| pc_wr_en | output | 1 | Program counter write enable, low during a stall |
| ifid_wr_en | output | 1 | Fetch/decode register write enable, low during a stall |
| ex_ctrl | output | CTRL_W | Control word held in the decode/execute register (zero after a bubble) |
| ex_rt | output | REG_W | Destination/second-source field held in the decode/execute register |

## Verification
The bench sweeps every combination of memory-read flag, load destination and both source fields for a narrow register width. This catches a design that stalls on a register-0 load, which would waste cycles on a discarded write. It also catches a design that ignores the second source field, which would read a stale operand. It checks that the cycle after every stall carries a zero control word and runs free. A design that forgot the bubble would let the load's memory-read flag repeat, or let the held instruction execute twice. Two short instruction streams, one dependent and one independent, are stepped through a bench-side fetch model to confirm a cost of exactly one cycle and zero cycles respectively.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

  // Number of source register fields read by a decoded instruction.
  localparam int unsigned LU_NUM_SRC = 2;

  // Index of each source field in the comparator bank.
  typedef enum logic {
    LU_SRC_A = 1'b0,
    LU_SRC_B = 1'b1
  } lu_src_e;

  // Reduction over per-source match flags.
  function automatic logic lu_any_hit(input logic [LU_NUM_SRC-1:0] hits);
    return |hits;
  endfunction

endpackage

// File: rtl/lu_field_match.sv
// One comparator: does the pending load write the register named by src_reg?
module lu_field_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic             load_pending,
  input  logic [REG_W-1:0] load_dst,
  input  logic [REG_W-1:0] src_reg,
  output logic             hit
);

  logic dst_is_zero;

  always_comb begin
    dst_is_zero = (load_dst == '0);
    // Register 0 is hard-wired, so a load into it carries no dependence.
    hit = load_pending && !dst_is_zero && (load_dst == src_reg);
  end

endmodule

// File: rtl/lu_stall_ctrl.sv
// Folds the comparator results into the front-end freeze and bubble controls.
module lu_stall_ctrl
  import lu_hazard_pkg::*;
(
  input  logic [LU_NUM_SRC-1:0] hits,
  output logic                  bubble,
  output logic                  pc_wr_en,
  output logic                  ifid_wr_en
);

  logic stall;

  always_comb begin
    stall      = lu_any_hit(hits);
    bubble     = stall;
    pc_wr_en   = !stall;
    ifid_wr_en = !stall;
  end

endmodule

// File: rtl/lu_idex_ctrl_reg.sv
// Control and destination slice of the decode/execute pipeline register.
module lu_idex_ctrl_reg #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bubble,
  input  logic [CTRL_W-1:0] id_ctrl,
  input  logic [REG_W-1:0]  id_rt,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [REG_W-1:0]  ex_rt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ctrl <= '0;
      ex_rt   <= '0;
    end else begin
      // A bubble leaves every downstream stage with nothing to do.
      ex_ctrl <= bubble ? '0 : id_ctrl;
      ex_rt   <= id_rt;
    end
  end

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_hazard_pkg::*;
#(
  parameter int unsigned REG_W     = 5,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned MEMRD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [REG_W-1:0]  ex_rt
);

  localparam int unsigned NSRC = LU_NUM_SRC;

  logic [REG_W-1:0] src_field [NSRC];
  logic [NSRC-1:0]  src_hit;
  logic             load_pending;
  logic             bubble;

  assign src_field[int'(LU_SRC_A)] = id_rs;
  assign src_field[int'(LU_SRC_B)] = id_rt;
  assign load_pending              = ex_ctrl[MEMRD_BIT];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    lu_field_match #(
      .REG_W(REG_W)
    ) match_i (
      .load_pending(load_pending),
      .load_dst    (ex_rt),
      .src_reg     (src_field[g]),
      .hit         (src_hit[g])
    );
  end

  lu_stall_ctrl stall_i (
    .hits      (src_hit),
    .bubble    (bubble),
    .pc_wr_en  (pc_wr_en),
    .ifid_wr_en(ifid_wr_en)
  );

  lu_idex_ctrl_reg #(
    .CTRL_W(CTRL_W),
    .REG_W (REG_W)
  ) idex_i (
    .clk    (clk),
    .rst    (rst),
    .bubble (bubble),
    .id_ctrl(id_ctrl),
    .id_rt  (id_rt),
    .ex_ctrl(ex_ctrl),
    .ex_rt  (ex_rt)
  );

endmodule

// File: rtl/lu_hazard_chk.sv
module lu_hazard_chk #(
  parameter int unsigned REG_W     = 5,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned MEMRD_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  id_rs,
  input logic [REG_W-1:0]  id_rt,
  input logic [CTRL_W-1:0] id_ctrl,
  input logic              pc_wr_en,
  input logic              ifid_wr_en,
  input logic [CTRL_W-1:0] ex_ctrl,
  input logic [REG_W-1:0]  ex_rt
);

  // R1
  a_r1_rs_dep_stalls: assert property (@(posedge clk) disable iff (rst)
    (ex_ctrl[MEMRD_BIT] && ex_rt != '0 && ex_rt == id_rs) |-> !pc_wr_en);

  // R2
  a_r2_rt_dep_stalls: assert property (@(posedge clk) disable iff (rst)
    (ex_ctrl[MEMRD_BIT] && ex_rt != '0 && ex_rt == id_rt) |-> !ifid_wr_en);

  // R3
  a_r3_zero_dst_free: assert property (@(posedge clk) disable iff (rst)
    (ex_rt == '0) |-> pc_wr_en);

  // R4
  a_r4_no_load_free: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl[MEMRD_BIT] |-> pc_wr_en);

  // R5
  a_r5_enables_agree: assert property (@(posedge clk) disable iff (rst)
    pc_wr_en == ifid_wr_en);

  // R6
  a_r6_bubble_zero: assert property (@(posedge clk) disable iff (rst)
    (!rst && !pc_wr_en) |=> (ex_ctrl == '0));

  // R6
  a_r6_ctrl_passes: assert property (@(posedge clk) disable iff (rst)
    (!rst && pc_wr_en) |=> (ex_ctrl == $past(id_ctrl)));

  // R6
  a_r6_rt_passes: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ex_rt == $past(id_rt)));

  // R7
  a_r7_single_stall: assert property (@(posedge clk) disable iff (rst)
    (!rst && !pc_wr_en) |=> pc_wr_en);

  // R8
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (ex_ctrl == '0 && ex_rt == '0));

endmodule

bind lu_hazard_unit lu_hazard_chk #(
  .REG_W    (REG_W),
  .CTRL_W   (CTRL_W),
  .MEMRD_BIT(MEMRD_BIT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .id_rs     (id_rs),
  .id_rt     (id_rt),
  .id_ctrl   (id_ctrl),
  .pc_wr_en  (pc_wr_en),
  .ifid_wr_en(ifid_wr_en),
  .ex_ctrl   (ex_ctrl),
  .ex_rt     (ex_rt)
);

// File: tb/lu_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module lu_hazard_unit_tb_top;

  localparam int RW = 3;
  localparam int CW = 4;
  localparam int MB = 1;
  localparam logic [CW-1:0] LOAD_CTRL  = 4'b0110; // memory-read bit 1 set
  localparam logic [CW-1:0] PLAIN_CTRL = 4'b1101; // memory-read bit 1 clear

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] id_rs = '0;
  logic [RW-1:0] id_rt = '0;
  logic [CW-1:0] id_ctrl = '0;
  logic          pc_wr_en, ifid_wr_en;
  logic [CW-1:0] ex_ctrl;
  logic [RW-1:0] ex_rt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lu_hazard_unit #(.REG_W(RW), .CTRL_W(CW), .MEMRD_BIT(MB)) dut_i (
    .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt), .id_ctrl(id_ctrl),
    .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .ex_ctrl(ex_ctrl), .ex_rt(ex_rt)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Step a three-instruction stream through a bench-side fetch model and
  // count edges until the third instruction has been latched into decode.
  task automatic run_stream(input logic [RW-1:0] use_rs, input logic [RW-1:0] use_rt,
                            output int cycles);
    logic          ld  [3];
    logic [RW-1:0] srs [3];
    logic [RW-1:0] srt [3];
    int pc;
    int ifid;
    logic en;
    ld[0] = 1'b1; srs[0] = 3'd1; srt[0] = 3'd2; // load into register 2
    ld[1] = 1'b0; srs[1] = use_rs; srt[1] = use_rt;
    ld[2] = 1'b0; srs[2] = 3'd4; srt[2] = 3'd5;
    ifid = 0; pc = 1; cycles = 0;
    while (ifid < 2 && cycles < 20) begin
      id_rs   = srs[ifid];
      id_rt   = srt[ifid];
      id_ctrl = ld[ifid] ? LOAD_CTRL : PLAIN_CTRL;
      #1;
      en = pc_wr_en;
      @(posedge clk);
      #1;
      cycles++;
      if (en) begin
        ifid = pc;
        pc++;
      end
    end
    id_ctrl = '0;
    tick();
  endtask

  initial begin
    int cyc_dep, cyc_dep_b, cyc_ind;
    // R8: reset state
    repeat (2) tick();
    id_ctrl = LOAD_CTRL; id_rt = 3'd3; id_rs = 3'd3;
    tick();
    check("R8", "ex_ctrl in reset", int'(ex_ctrl), 0);
    check("R8", "ex_rt in reset", int'(ex_rt), 0);
    check("R8", "pc_wr_en in reset", int'(pc_wr_en), 1);
    check("R8", "ifid_wr_en in reset", int'(ifid_wr_en), 1);
    rst = 1'b0;
    id_ctrl = '0;
    tick();

    // Exhaustive sweep R1 R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < (1 << RW); d++) begin
        for (int s = 0; s < (1 << RW); s++) begin
          for (int t = 0; t < (1 << RW); t++) begin
            bit exp_stall;
            logic [CW-1:0] lctrl;
            lctrl = (m != 0) ? LOAD_CTRL : PLAIN_CTRL;
            exp_stall = (m != 0) && (d != 0) && (d == s || d == t);
            id_ctrl = '0; tick();               // clear execute slot
            id_ctrl = lctrl; id_rt = RW'(d); id_rs = '0;
            tick();                              // older instruction enters execute
            check("R6", "ex_rt load", int'(ex_rt), d);
            check("R6", "ex_ctrl load", int'(ex_ctrl), int'(lctrl));
            id_rs = RW'(s); id_rt = RW'(t); id_ctrl = PLAIN_CTRL;
            #1;
            if (m == 0)
              check("R4", "pc_wr_en no load", int'(pc_wr_en), 1);
            else if (d == 0)
              check("R3", "pc_wr_en zero dst", int'(pc_wr_en), 1);
            else if (d == s)
              check("R1", "pc_wr_en rs dep", int'(pc_wr_en), int'(!exp_stall));
            else
              check("R2", "pc_wr_en rt", int'(pc_wr_en), int'(!exp_stall));
            check("R5", "ifid_wr_en", int'(ifid_wr_en), int'(!exp_stall));
            tick();
            check("R6", "ex_ctrl after edge", int'(ex_ctrl),
                  exp_stall ? 0 : int'(PLAIN_CTRL));
            if (exp_stall)
              check("R7", "no second stall", int'(pc_wr_en), 1);
          end
        end
      end
    end

    // R9: cycle cost of a dependent versus an independent successor
    run_stream(3'd2, 3'd6, cyc_dep);
    run_stream(3'd7, 3'd2, cyc_dep_b);
    run_stream(3'd6, 3'd7, cyc_ind);
    check("R9", "independent cycles", cyc_ind, 2);
    check("R9", "dependent rs cycles", cyc_dep, cyc_ind + 1);
    check("R9", "dependent rt cycles", cyc_dep_b, cyc_ind + 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule